// File: doc/BRIEF.md
# Pre-divider clock generator

This block produces a divided clock for consumers such as a pixel pipeline or an audio master clock. It chooses one of three reference sources, applies a pre-divide ratio of 2, 2.5 or 3, follows it with an integer divide, and gates the result with an enable bit. Every reference arrives as a one-cycle tick strobe on the system clock, and each tick marks twice the rate of that source. Counting doubled-rate ticks lets the 2.5 ratio come out as a whole number of ticks, so no logic has to work on both clock edges.

A 16-bit control word holds all the settings. When the enable bit is set and the fields are legal, the block runs a three-state machine: ST_IDLE, ST_HIGH and ST_LOW. The transitions are:
- start: ST_IDLE to ST_HIGH, on a selected tick while the block is enabled and the fields are legal.
- half: ST_HIGH to ST_LOW, when the high phase completes.
- wrap: ST_LOW to ST_HIGH, when the low phase completes and the fields are still legal.
- stop: ST_LOW to ST_IDLE, when the low phase completes and the fields are now illegal.
- off: any state to ST_IDLE, as soon as the enable bit is clear.

Field changes are latched only at start or wrap, so an output period is never cut short. The outputs are a toggling clock and a one-cycle clock-enable strobe on each rising edge.

Top module: `prediv_clkgen`

## Requirements
- R1: While reset is asserted, and after reset is released with the enable bit clear, clk_out and clk_en are both 0.
- R2: Source select uses ctrl bit 14 (esel) and bit 13 (psel). With esel=0, ref_tick[0] is counted whatever psel holds. With esel=1 and psel=0, ref_tick[1] is counted. With esel=1 and psel=1, ref_tick[2] is counted.
- R3: One output period lasts (code+3)*div selected ticks. The pre-divide code is ctrl[9:8] and the divide value is ctrl[6:0]. Codes 1, 2 and 3 give ratios 2, 2.5 and 3.
- R4: The high phase lasts ceil(N/2) ticks and the low phase lasts floor(N/2) ticks, where N is the tick count of one period. For an odd N the high phase is one tick longer.
- R5: A divide value below 2, or a pre-divide code of 0, is illegal. Such a setting never starts a period, and clk_out and clk_en stay 0.
- R6: The enable bit is ctrl bit 15. When it is 0, clk_out is 0 from the next cycle on and the counter is cleared. Setting it again resumes with the unchanged divider fields.
- R7: A change to the source, code or divide fields while running takes effect only from the next period boundary. The period in progress completes with its old lengths.
- R8: clk_en is a single-cycle strobe. It is high exactly in the first cycle of each high phase of clk_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 3 | Per-source tick strobes, each at twice its source rate |
| ctrl | input | 16 | Control word: enable, esel, psel, pre-divide code, divide value |
| clk_en | output | 1 | One-cycle strobe at each rising edge of clk_out |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench measures every high and low phase in system cycles and compares each against a queue of expected lengths computed from the formula. It covers all three sources, driven at different tick spacings, so a swapped esel/psel decode shows up as a wrong phase length. It also covers an odd tick count, where a design with the wrong rounding gives the extra tick to the low phase. It covers the largest divide value, where a counter that is too narrow wraps early. A mid-period reprogram must leave the running period intact, and a design that loads fields immediately would produce a runt period. Illegal divide values and pre-divide code 0 must keep the output silent. Clearing the enable bit must force the output low, and a design that ignores it would keep toggling.

// File: rtl/prediv_pkg.sv
package prediv_pkg;

    localparam int CTRL_W    = 16;
    localparam int EN_BIT    = 15;
    localparam int ESEL_BIT  = 14;
    localparam int PSEL_BIT  = 13;
    localparam int PCODE_LSB = 8;
    localparam int PCODE_W   = 2;
    localparam int DIV_LSB   = 0;
    localparam int MAX_RATIO = 6;     // twice the largest pre-divide (3)

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_t;

    // esel clear picks source 0 regardless of psel
    function automatic logic [1:0] src_of(input logic esel, input logic psel);
        if (!esel)
            return 2'd0;
        else if (!psel)
            return 2'd1;
        else
            return 2'd2;
    endfunction

endpackage

// File: rtl/prediv_cfg_decode.sv
module prediv_cfg_decode
    import prediv_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int MIN_DIV = 2,
    parameter int CNT_W   = 10
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic              en,
    output logic [1:0]        src,
    output logic              valid,
    output logic [CNT_W-1:0]  hi_len,
    output logic [CNT_W-1:0]  lo_len
);

    logic [PCODE_W-1:0] pcode;
    logic [DIV_W-1:0]   divv;
    logic [2:0]         ratio;
    logic [CNT_W-1:0]   total;
    logic               unused_bits;

    assign en    = ctrl[EN_BIT];
    assign src   = src_of(ctrl[ESEL_BIT], ctrl[PSEL_BIT]);
    assign pcode = ctrl[PCODE_LSB +: PCODE_W];
    assign divv  = ctrl[DIV_LSB +: DIV_W];
    assign unused_bits = ^{ctrl[12:10], ctrl[7]};

    // doubled pre-divide ratio: 4, 5 or 6
    assign ratio = {1'b0, pcode} + 3'd3;
    assign total = CNT_W'(ratio) * CNT_W'(divv);

    assign valid  = (pcode != '0) && (int'(divv) >= MIN_DIV);
    assign lo_len = total >> 1;
    assign hi_len = (total >> 1) + {{(CNT_W-1){1'b0}}, total[0]};

endmodule

// File: rtl/prediv_src_mux.sv
module prediv_src_mux #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] ref_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = ref_tick[g] && (sel == SEL_W'(g));
    end

    assign tick = |hit;

endmodule

// File: rtl/prediv_phase_fsm.sv
module prediv_phase_fsm
    import prediv_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             valid,
    input  logic [SEL_W-1:0] live_src,
    input  logic [CNT_W-1:0] live_hi,
    input  logic [CNT_W-1:0] live_lo,
    input  logic             tick,
    output logic [SEL_W-1:0] use_src,
    output logic             clk_out,
    output logic             clk_en
);

    phase_t           state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W-1:0] sh_hi, sh_lo;
    logic [SEL_W-1:0] sh_src;
    logic             load;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign use_src = (state == ST_IDLE) ? live_src : sh_src;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        load      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nxt_cnt = '0;
                if (en && valid && tick) begin          // start
                    nxt_state = ST_HIGH;
                    nxt_cnt   = ONE;
                    load      = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!en) begin                          // off
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end else if (tick) begin
                    if (cnt == sh_hi) begin             // half
                        nxt_state = ST_LOW;
                        nxt_cnt   = ONE;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
            end
            ST_LOW: begin
                if (!en) begin                          // off
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end else if (tick) begin
                    if (cnt == sh_lo) begin
                        if (valid) begin                // wrap
                            nxt_state = ST_HIGH;
                            nxt_cnt   = ONE;
                            load      = 1'b1;
                        end else begin                  // stop
                            nxt_state = ST_IDLE;
                            nxt_cnt   = '0;
                        end
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh_hi  <= '0;
            sh_lo  <= '0;
            sh_src <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            if (load) begin
                sh_hi  <= live_hi;
                sh_lo  <= live_lo;
                sh_src <= live_src;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_out <= 1'b0;
            clk_en  <= 1'b0;
        end else begin
            clk_out <= (nxt_state == ST_HIGH);
            clk_en  <= (nxt_state == ST_HIGH) && (state != ST_HIGH);
        end
    end

endmodule

// File: rtl/prediv_clkgen.sv
module prediv_clkgen
    import prediv_pkg::*;
#(
    parameter int DIV_W   = 7,
    parameter int MIN_DIV = 2,
    parameter int N_SRC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  ref_tick,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              clk_en,
    output logic              clk_out
);

    localparam int MAX_TOTAL = MAX_RATIO * ((1 << DIV_W) - 1);
    localparam int CNT_W     = $clog2(MAX_TOTAL + 1);
    localparam int SEL_W     = 2;

    logic             en, valid, tick;
    logic [1:0]       src;
    logic [SEL_W-1:0] use_src;
    logic [CNT_W-1:0] hi_len, lo_len;

    prediv_cfg_decode #(
        .DIV_W   (DIV_W),
        .MIN_DIV (MIN_DIV),
        .CNT_W   (CNT_W)
    ) u_dec (
        .ctrl   (ctrl),
        .en     (en),
        .src    (src),
        .valid  (valid),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    prediv_src_mux #(
        .N_SRC (N_SRC),
        .SEL_W (SEL_W)
    ) u_mux (
        .ref_tick (ref_tick),
        .sel      (use_src),
        .tick     (tick)
    );

    prediv_phase_fsm #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .valid    (valid),
        .live_src (src),
        .live_hi  (hi_len),
        .live_lo  (lo_len),
        .tick     (tick),
        .use_src  (use_src),
        .clk_out  (clk_out),
        .clk_en   (clk_en)
    );

endmodule

// File: rtl/prediv_clkgen_chk.sv
module prediv_clkgen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ctrl,
    input logic        clk_en,
    input logic        clk_out
);

    logic cfg_ok;
    logic unused_bits;

    assign cfg_ok      = ctrl[15] && (ctrl[9:8] != 2'd0) && (ctrl[6:0] >= 7'd2);
    assign unused_bits = ^{ctrl[14:10], ctrl[7]};

    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[15] |=> !clk_out);

    assert_strobe_at_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (clk_out && !$past(clk_out)));

    assert_rise_has_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> clk_en);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> !clk_en);

    assert_start_needs_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> $past(cfg_ok));

endmodule

bind prediv_clkgen prediv_clkgen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .clk_en  (clk_en),
    .clk_out (clk_out)
);

// File: tb/prediv_clkgen_tb.sv
`timescale 1ns/1ps
module prediv_clkgen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ref_tick = 3'b000;
    logic [15:0] ctrl = 16'h0000;
    logic        clk_en, clk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int    q_hi[$];
    int    q_lo[$];
    string q_tag[$];

    bit mon_flush = 1'b0;
    bit prev_out  = 1'b0;
    bit have      = 1'b0;
    int hcnt = 0, lcnt = 0;
    int rises = 0, strobes = 0;

    always #2 clk = ~clk;   // 250 MHz

    prediv_clkgen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .ctrl     (ctrl),
        .clk_en   (clk_en),
        .clk_out  (clk_out)
    );

    // source 0 ticks every cycle, source 1 every 2nd, source 2 every 3rd
    initial begin
        int c2 = 0;
        int c3 = 0;
        forever begin
            @(negedge clk);
            ref_tick[0] = 1'b1;
            ref_tick[1] = (c2 == 0);
            ref_tick[2] = (c3 == 0);
            c2 = (c2 + 1) % 2;
            c3 = (c3 + 1) % 3;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measure each period and compare with the scoreboard queue
    always @(negedge clk) begin
        if (mon_flush) begin
            have     = 1'b0;
            prev_out = clk_out;
            q_hi.delete();
            q_lo.delete();
            q_tag.delete();
        end else begin
            if (clk_en) strobes++;
            if (clk_out && !prev_out) begin
                rises++;
                if (have && q_hi.size() > 0) begin
                    int eh, el;
                    string t;
                    eh = q_hi.pop_front();
                    el = q_lo.pop_front();
                    t  = q_tag.pop_front();
                    check(hcnt == eh, {t, " high phase"}, hcnt, eh);
                    check(lcnt == el, {t, " low phase"}, lcnt, el);
                end
                hcnt = 1;
                lcnt = 0;
                have = 1'b1;
            end else if (have) begin
                if (clk_out) hcnt++;
                else         lcnt++;
            end
            prev_out = clk_out;
        end
    end

    function automatic logic [15:0] mk(input bit en, input bit esel, input bit psel,
                                       input int code, input int dv);
        return {en, esel, psel, 3'b000, 2'(code), 1'b0, 7'(dv)};
    endfunction

    // driver: push expected periods (in system cycles) and wait for them
    task automatic expect_run(input int code, input int dv, input int tp,
                              input int n, input string tag);
        int tot, eh, el;
        tot = (code + 3) * dv;
        eh  = ((tot + 1) / 2) * tp;
        el  = (tot / 2) * tp;
        for (int i = 0; i < n; i++) begin
            q_hi.push_back(eh);
            q_lo.push_back(el);
            q_tag.push_back(tag);
        end
        while (q_hi.size() > 0) @(negedge clk);
    endtask

    task automatic restart(input logic [15:0] w);
        @(negedge clk);
        ctrl = {1'b0, w[14:0]};
        repeat (3) @(negedge clk);
        mon_flush = 1'b1;
        @(negedge clk);
        mon_flush = 1'b0;
        ctrl = w;
    endtask

    task automatic silent_window(input logic [15:0] w, input string tag);
        int r0, s0;
        restart(w);
        r0 = rises;
        s0 = strobes;
        repeat (200) @(negedge clk);
        check(rises == r0, {tag, " no rising edge"}, rises - r0, 0);
        check(strobes == s0, {tag, " no strobe"}, strobes - s0, 0);
    endtask

    initial begin
        int r0, s0;
        repeat (4) @(negedge clk);
        check(clk_out == 1'b0, "R1 clk_out in reset", clk_out, 0);
        check(clk_en == 1'b0, "R1 clk_en in reset", clk_en, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(clk_out == 1'b0 && rises == 0, "R1 idle after reset", rises, 0);

        // R3: code 1 (ratio 2), div 2, source 0
        restart(mk(1, 0, 0, 1, 2));
        expect_run(1, 2, 1, 3, "R3 code1 div2");
        check(strobes == rises, "R8 strobe per rise", strobes, rises);

        // R2/R4: esel=0 with psel=1 still source 0; odd count 15
        restart(mk(1, 0, 1, 2, 3));
        expect_run(2, 3, 1, 3, "R2 R4 psel ignored odd");

        // R2: esel=1 psel=0 -> source 1 (every 2nd cycle)
        restart(mk(1, 1, 0, 3, 5));
        expect_run(3, 5, 2, 2, "R2 src1 code3");

        // R2: esel=1 psel=1 -> source 2 (every 3rd cycle)
        restart(mk(1, 1, 1, 2, 2));
        expect_run(2, 2, 3, 2, "R2 src2 code2");

        // R7: reprogram early in a high phase
        repeat (2) @(negedge clk);
        ctrl = mk(1, 1, 1, 1, 3);
        q_hi.push_back(15); q_lo.push_back(15); q_tag.push_back("R7 old period kept");
        expect_run(1, 3, 3, 2, "R7 new period");

        // R6: clear enable while running
        repeat (2) @(negedge clk);
        ctrl[15] = 1'b0;
        repeat (2) @(negedge clk);
        check(clk_out == 1'b0, "R6 low after disable", clk_out, 0);
        r0 = rises;
        repeat (100) @(negedge clk);
        check(rises == r0 && clk_out == 1'b0, "R6 stays low", rises - r0, 0);
        restart(mk(1, 1, 1, 1, 3));
        expect_run(1, 3, 3, 2, "R6 resume same fields");

        // R3 boundary: largest divide value
        restart(mk(1, 0, 0, 1, 127));
        expect_run(1, 127, 1, 2, "R3 div127");

        // R5: illegal settings stay silent
        silent_window(mk(1, 0, 0, 1, 1), "R5 div1");
        silent_window(mk(1, 0, 0, 3, 0), "R5 div0");
        silent_window(mk(1, 0, 0, 0, 10), "R5 code0");
        check(clk_out == 1'b0, "R5 output low", clk_out, 0);

        s0 = strobes;
        check(s0 == rises, "R8 strobe total", s0, rises);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule